// File: doc/BRIEF.md
# APB Master with Byte-Packing Buffer

This block is the bus side of a serial-to-APB bridge. A serial target front-end hands it one-cycle strobes: a 32-bit register address, single data bytes, a cancel, a load request for read data, and a request to advance through read bytes. On the write path, bytes queue in a byte-wide FIFO. Every four bytes form one 32-bit word, and each complete word becomes one APB write. Successive words go to consecutive word addresses, starting at the captured address.

On the read path, a load strobe starts four APB reads. They fetch four consecutive words into a small word buffer, and the front-end then takes the data out one byte at a time. A busy indication goes back upstream so the front-end can refuse a byte with a not-acknowledge. A sticky flag records any write that the slave ended with an error.

Top module: `apb_byte_bridge`

## Requirements
- R1: A pulse on `addrValid` captures `addrIn`. The first word written after it goes to that address, and each later write goes 4 bytes higher. A cancel does not reset this address progression.
- R2: Within a written word, the first byte received is placed in bits [31:24] and the fourth byte in bits [7:0].
- R3: The FIFO holds 256 bytes. While it is full, `busyNack` is high and an offered byte is dropped. A dropped byte never appears in any later write.
- R4: Exactly one APB write is issued per four accepted bytes. Fewer than four outstanding bytes cause no bus activity.
- R5: Each transfer spends one cycle with `psel`=1 and `penable`=0, then holds `psel`=1 and `penable`=1 until `pready` is 1. `paddr`, `pwrite` and `pwdata` stay unchanged while it waits.
- R6: `busyNack` is high while an access phase is waiting on `pready`=0, and low again once the bus is idle and the FIFO is not full.
- R7: `pslverr`=1 on a completing write sets `wrError`, which stays set until the next `addrValid`. `pslverr` on a read has no effect on it.
- R8: `cancelReq` discards the bytes of an incomplete word. The next byte starts a fresh word in bits [31:24].
- R9: A `loadReq` performs four APB reads (`pwrite`=0) at the captured address, +4, +8 and +12. `rdEmpty` stays 1 until all four words are stored.
- R10: Read bytes are presented on `rdByte` most significant byte first, word 0 first. Each `rdByteReq` moves to the next byte. After 16 bytes `rdEmpty` is 1, and further requests change nothing.
- R11: Pending write words are issued before the reads of a load.
- R12: After reset, `psel`, `penable`, `busyNack` and `wrError` are 0 and `rdEmpty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addrIn | input | 32 | Register address from the front-end |
| addrValid | input | 1 | Capture strobe for addrIn |
| byteIn | input | 8 | Write data byte |
| byteValid | input | 1 | Push strobe for byteIn |
| cancelReq | input | 1 | Discard incomplete word |
| loadReq | input | 1 | Start a four-word read fill |
| rdByteReq | input | 1 | Advance to next read byte |
| rdByte | output | 8 | Current read byte |
| rdEmpty | output | 1 | No read byte available |
| busyNack | output | 1 | Refuse further bytes |
| wrError | output | 1 | Sticky write error |
| paddr | output | 32 | APB address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| pwdata | output | 32 | APB write data |
| pready | input | 1 | APB ready |
| prdata | input | 32 | APB read data |
| pslverr | input | 1 | APB error |

## Verification
The hardest condition to reach from the ports is a full FIFO with a byte offered on top of it. Normally the bus drains words as fast as bytes arrive. The stimulus therefore holds `pready` low, so the first write stalls in its access phase, and then pushes 256 bytes followed by one extra byte. After `pready` is released, the last of the 64 drained words and the next freshly pushed word show whether the extra byte was stored. Write-before-read ordering is reached the same way: two words are stalled behind a low `pready` when the load arrives.

// File: rtl/abb_pkg.sv
package abb_pkg;
  typedef struct packed {
    logic startWr;
    logic startRd;
    logic doneWr;
    logic doneRd;
  } apbStrobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS} apbPhase_t;
endpackage

// File: rtl/abb_control.sv
module abb_control
  import abb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wantWr,
  input  logic       wantRd,
  input  logic       pready,
  output apbStrobe_t stb,
  output logic       psel,
  output logic       penable,
  output logic       pwrite
);
  apbPhase_t phase;
  logic      isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      isWrite <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (wantWr) begin
            phase   <= PH_SETUP;
            isWrite <= 1'b1;
          end else if (wantRd) begin
            phase   <= PH_SETUP;
            isWrite <= 1'b0;
          end
        end
        PH_SETUP:  phase <= PH_ACCESS;
        PH_ACCESS: if (pready) phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.startWr = (phase == PH_IDLE) && wantWr;
    stb.startRd = (phase == PH_IDLE) && !wantWr && wantRd;
    stb.doneWr  = (phase == PH_ACCESS) && pready && isWrite;
    stb.doneRd  = (phase == PH_ACCESS) && pready && !isWrite;
  end

  assign psel    = (phase != PH_IDLE);
  assign penable = (phase == PH_ACCESS);
  assign pwrite  = isWrite;

  // R5: setup lasts one cycle and is followed by access
  assert_setup_then_access_R5: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !penable) |=> (psel && penable));

  // R5: access holds until ready
  assert_access_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (penable && !pready) |=> (psel && penable));
endmodule

// File: rtl/abb_datapath.sv
module abb_datapath
  import abb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 256,
  parameter int RD_WORDS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrValid,
  input  logic [7:0]        byteIn,
  input  logic              byteValid,
  input  logic              cancelReq,
  input  logic              loadReq,
  input  logic              rdByteReq,
  input  apbStrobe_t        stb,
  input  logic              pslverr,
  input  logic [DATA_W-1:0] prdata,
  output logic              wantWr,
  output logic              wantRd,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  output logic              fifoFull,
  output logic              wrError,
  output logic [7:0]        rdByte,
  output logic              rdEmpty
);
  localparam int BYTES    = DATA_W / 8;
  localparam int BSEL_W   = $clog2(BYTES);
  localparam int PTR_W    = $clog2(FIFO_DEPTH);
  localparam int RD_IDX_W = $clog2(RD_WORDS);
  localparam int RD_BYTES = RD_WORDS * BYTES;
  localparam int RDP_W    = $clog2(RD_BYTES + 1);

  // write FIFO
  logic [7:0]        fifoMem [FIFO_DEPTH];
  logic [PTR_W:0]    wrPtr, rdPtr, fifoCount, wordsPend;
  logic [BSEL_W-1:0] partCnt;
  logic              pushOk, wordDone;
  logic [ADDR_W-1:0] baseAddr, wrWordIdx;
  logic [DATA_W-1:0] headWord;

  assign fifoCount = wrPtr - rdPtr;
  assign fifoFull  = (fifoCount == (PTR_W+1)'(FIFO_DEPTH));
  assign pushOk    = byteValid && !fifoFull && !cancelReq;
  assign wordDone  = pushOk && (partCnt == BSEL_W'(BYTES-1));
  assign wantWr    = (wordsPend != '0);

  always_ff @(posedge clk) begin
    if (pushOk) fifoMem[wrPtr[PTR_W-1:0]] <= byteIn;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_head
    logic [PTR_W-1:0] slot;
    assign slot = rdPtr[PTR_W-1:0] + PTR_W'(b);
    assign headWord[DATA_W-1-8*b -: 8] = fifoMem[slot];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      partCnt   <= '0;
      wordsPend <= '0;
      baseAddr  <= '0;
      wrWordIdx <= '0;
      wrError   <= 1'b0;
      paddr     <= '0;
      pwdata    <= '0;
    end else begin
      if (cancelReq) begin
        wrPtr   <= wrPtr - {{(PTR_W+1-BSEL_W){1'b0}}, partCnt};
        partCnt <= '0;
      end else if (pushOk) begin
        wrPtr   <= wrPtr + 1'b1;
        partCnt <= partCnt + 1'b1;
      end
      if (stb.doneWr) rdPtr <= rdPtr + (PTR_W+1)'(BYTES);
      case ({wordDone, stb.doneWr})
        2'b10:   wordsPend <= wordsPend + 1'b1;
        2'b01:   wordsPend <= wordsPend - 1'b1;
        default: ;
      endcase
      if (addrValid) begin
        baseAddr  <= addrIn;
        wrWordIdx <= '0;
      end else if (stb.doneWr) begin
        wrWordIdx <= wrWordIdx + 1'b1;
      end
      if (stb.doneWr && pslverr) wrError <= 1'b1;
      else if (addrValid)        wrError <= 1'b0;
      if (stb.startWr) begin
        paddr  <= baseAddr + {wrWordIdx[ADDR_W-1-BSEL_W:0], {BSEL_W{1'b0}}};
        pwdata <= headWord;
      end else if (stb.startRd) begin
        paddr  <= baseAddr + ADDR_W'({fillIdx, {BSEL_W{1'b0}}});
      end
    end
  end

  // read buffer
  logic [DATA_W-1:0]   rdBuf [RD_WORDS];
  logic [RD_IDX_W:0]   fillIdx;
  logic                fillActive, rdValid;
  logic [RDP_W-1:0]    rdBytePtr;
  logic [RD_IDX_W-1:0] selWord;
  logic [BSEL_W-1:0]   selByte;
  logic [DATA_W-1:0]   shifted;

  assign wantRd  = fillActive;
  assign rdEmpty = !rdValid || (rdBytePtr == RDP_W'(RD_BYTES));
  assign selWord = rdBytePtr[BSEL_W +: RD_IDX_W];
  assign selByte = rdBytePtr[BSEL_W-1:0];
  assign shifted = rdBuf[selWord] << {selByte, 3'b000};
  assign rdByte  = shifted[DATA_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (stb.doneRd) rdBuf[fillIdx[RD_IDX_W-1:0]] <= prdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillIdx    <= '0;
      fillActive <= 1'b0;
      rdValid    <= 1'b0;
      rdBytePtr  <= '0;
    end else begin
      if (loadReq && !fillActive) begin
        fillActive <= 1'b1;
        fillIdx    <= '0;
        rdValid    <= 1'b0;
        rdBytePtr  <= '0;
      end else begin
        if (stb.doneRd) begin
          fillIdx <= fillIdx + 1'b1;
          if (fillIdx == (RD_IDX_W+1)'(RD_WORDS-1)) begin
            fillActive <= 1'b0;
            rdValid    <= 1'b1;
          end
        end
        if (rdByteReq && !rdEmpty) rdBytePtr <= rdBytePtr + 1'b1;
      end
    end
  end

  // R3: a byte offered while full leaves the write pointer untouched
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && byteValid && !cancelReq) |=> (wrPtr == $past(wrPtr)));

  // R4: pending words never exceed the bytes actually queued
  assert_pend_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    ({wordsPend, {BSEL_W{1'b0}}} <= {{BSEL_W{1'b0}}, fifoCount}));

  // R10: an exhausted buffer does not advance
  assert_empty_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEmpty && !loadReq) |=> $stable(rdBytePtr));
endmodule

// File: rtl/apb_byte_bridge.sv
module apb_byte_bridge
  import abb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 256,
  parameter int RD_WORDS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrValid,
  input  logic [7:0]        byteIn,
  input  logic              byteValid,
  input  logic              cancelReq,
  input  logic              loadReq,
  input  logic              rdByteReq,
  output logic [7:0]        rdByte,
  output logic              rdEmpty,
  output logic              busyNack,
  output logic              wrError,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);
  apbStrobe_t stb;
  logic       wantWr, wantRd, fifoFull;

  abb_control u_ctl (
    .clk(clk), .rstN(rstN), .wantWr(wantWr), .wantRd(wantRd), .pready(pready),
    .stb(stb), .psel(psel), .penable(penable), .pwrite(pwrite)
  );

  abb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .RD_WORDS(RD_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrValid(addrValid),
    .byteIn(byteIn), .byteValid(byteValid), .cancelReq(cancelReq),
    .loadReq(loadReq), .rdByteReq(rdByteReq), .stb(stb), .pslverr(pslverr),
    .prdata(prdata), .wantWr(wantWr), .wantRd(wantRd), .paddr(paddr),
    .pwdata(pwdata), .fifoFull(fifoFull), .wrError(wrError),
    .rdByte(rdByte), .rdEmpty(rdEmpty)
  );

  assign busyNack = fifoFull || (penable && !pready);

  // R5: transfer attributes frozen while waiting
  assert_stall_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (penable && !pready) |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  // R7: error flag only rises after an erroring write completion
  assert_err_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrError) |-> $past(psel && penable && pready && pwrite && pslverr));
endmodule

// File: tb/sim_apb_byte_bridge.sv
module sim_apb_byte_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] addrIn = '0;
  logic        addrValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        byteValid = 1'b0, cancelReq = 1'b0, loadReq = 1'b0, rdByteReq = 1'b0;
  logic [7:0]  rdByte;
  logic        rdEmpty, busyNack, wrError;
  logic [31:0] paddr, pwdata, prdata;
  logic        psel, penable, pwrite, pready, pslverr;
  logic        readyEn = 1'b1, errEn = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [31:0] logAddr [512];
  logic [31:0] logData [512];
  logic        logWr   [512];
  int          logN = 0;

  always #4 clk = ~clk;

  assign pready  = readyEn;
  assign pslverr = errEn;
  assign prdata  = {paddr[15:0], ~paddr[15:0]};

  apb_byte_bridge u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrValid(addrValid),
    .byteIn(byteIn), .byteValid(byteValid), .cancelReq(cancelReq),
    .loadReq(loadReq), .rdByteReq(rdByteReq), .rdByte(rdByte), .rdEmpty(rdEmpty),
    .busyNack(busyNack), .wrError(wrError), .paddr(paddr), .psel(psel),
    .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .pready(pready),
    .prdata(prdata), .pslverr(pslverr)
  );

  always @(negedge clk) begin
    if (rstN && psel && penable && pready && logN < 512) begin
      logAddr[logN] = paddr;
      logData[logN] = pwrite ? pwdata : prdata;
      logWr[logN]   = pwrite;
      logN++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setAddr(logic [31:0] a);
    addrIn = a; addrValid = 1'b1;
    @(negedge clk); addrValid = 1'b0;
  endtask

  task automatic pushByte(logic [7:0] b);
    byteIn = b; byteValid = 1'b1;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectLog(int idx, logic [31:0] a, logic [31:0] d, logic w, string req);
    chk({req, " addr"}, logAddr[idx], a);
    chk({req, " data"}, logData[idx], d);
    chk({req, " dir"},  {31'd0, logWr[idx]}, {31'd0, w});
  endtask

  task automatic testReset();
    chk("R12 psel", {31'd0, psel}, 32'd0);
    chk("R12 penable", {31'd0, penable}, 32'd0);
    chk("R12 busyNack", {31'd0, busyNack}, 32'd0);
    chk("R12 wrError", {31'd0, wrError}, 32'd0);
    chk("R12 rdEmpty", {31'd0, rdEmpty}, 32'd1);
  endtask

  task automatic testWrite();
    int n0 = logN;
    setAddr(32'h1000_0010);
    pushByte(8'h11); pushByte(8'h22); pushByte(8'h33); pushByte(8'h44);
    pushByte(8'h55); pushByte(8'h66); pushByte(8'h77); pushByte(8'h88);
    waitCyc(12);
    chk("R4 two writes", logN - n0, 2);
    expectLog(n0,   32'h1000_0010, 32'h1122_3344, 1'b1, "R1 R2 word0");
    expectLog(n0+1, 32'h1000_0014, 32'h5566_7788, 1'b1, "R1 R2 word1");
  endtask

  task automatic testPartialCancel();
    int n0 = logN;
    pushByte(8'hAA); pushByte(8'hBB); pushByte(8'hCC);
    waitCyc(10);
    chk("R4 partial no write", logN - n0, 0);
    cancelReq = 1'b1; @(negedge clk); cancelReq = 1'b0;
    pushByte(8'h01); pushByte(8'h02); pushByte(8'h03); pushByte(8'h04);
    waitCyc(10);
    chk("R8 one write after cancel", logN - n0, 1);
    expectLog(n0, 32'h1000_0018, 32'h0102_0304, 1'b1, "R8 fresh word");
  endtask

  task automatic testWait();
    int n0;
    readyEn = 1'b0;
    setAddr(32'h2000_0000);
    n0 = logN;
    pushByte(8'hA1); pushByte(8'hA2); pushByte(8'hA3); pushByte(8'hA4);
    waitCyc(6);
    chk("R5 held access", {30'd0, psel, penable}, 32'd3);
    chk("R5 stalled addr", paddr, 32'h2000_0000);
    chk("R6 busy while waiting", {31'd0, busyNack}, 32'd1);
    chk("R5 no completion", logN - n0, 0);
    readyEn = 1'b1;
    waitCyc(4);
    chk("R5 completed", logN - n0, 1);
    expectLog(n0, 32'h2000_0000, 32'hA1A2_A3A4, 1'b1, "R5 stalled word");
    chk("R6 busy released", {31'd0, busyNack}, 32'd0);
  endtask

  task automatic testError();
    errEn = 1'b1;
    pushByte(8'h01); pushByte(8'h02); pushByte(8'h03); pushByte(8'h04);
    waitCyc(6);
    errEn = 1'b0;
    chk("R7 error set", {31'd0, wrError}, 32'd1);
    pushByte(8'h05); pushByte(8'h06); pushByte(8'h07); pushByte(8'h08);
    waitCyc(6);
    chk("R7 error sticky", {31'd0, wrError}, 32'd1);
    setAddr(32'h2100_0000);
    chk("R7 error cleared", {31'd0, wrError}, 32'd0);
  endtask

  task automatic testFull();
    int n0;
    readyEn = 1'b0;
    setAddr(32'h3000_0000);
    n0 = logN;
    for (int i = 0; i < 256; i++) pushByte(8'(i));
    chk("R3 busy when full", {31'd0, busyNack}, 32'd1);
    pushByte(8'hEE);
    readyEn = 1'b1;
    waitCyc(240);
    chk("R3 drained words", logN - n0, 64);
    expectLog(n0,    32'h3000_0000, 32'h0001_0203, 1'b1, "R3 first word");
    expectLog(n0+63, 32'h3000_00FC, 32'hFCFD_FEFF, 1'b1, "R3 last word");
    chk("R3 busy after drain", {31'd0, busyNack}, 32'd0);
    pushByte(8'h10); pushByte(8'h11); pushByte(8'h12); pushByte(8'h13);
    waitCyc(8);
    expectLog(n0+64, 32'h3000_0100, 32'h1011_1213, 1'b1, "R3 dropped byte absent");
  endtask

  task automatic testRead();
    int n0;
    logic [31:0] a;
    logic [31:0] w;
    setAddr(32'h4000_0100);
    n0 = logN;
    errEn = 1'b1;
    loadReq = 1'b1; @(negedge clk); loadReq = 1'b0;
    chk("R9 empty during fill", {31'd0, rdEmpty}, 32'd1);
    waitCyc(20);
    errEn = 1'b0;
    chk("R9 four reads", logN - n0, 4);
    for (int k = 0; k < 4; k++) begin
      a = 32'h4000_0100 + 32'(4*k);
      expectLog(n0+k, a, {a[15:0], ~a[15:0]}, 1'b0, "R9 read");
    end
    chk("R7 read error ignored", {31'd0, wrError}, 32'd0);
    chk("R9 filled", {31'd0, rdEmpty}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      a = 32'h4000_0100 + 32'(4*(k/4));
      w = {a[15:0], ~a[15:0]};
      w = w << (8*(k%4));
      chk("R10 byte order", {24'd0, rdByte}, {24'd0, w[31:24]});
      chk("R10 not empty", {31'd0, rdEmpty}, 32'd0);
      rdByteReq = 1'b1; @(negedge clk); rdByteReq = 1'b0;
    end
    chk("R10 empty after 16", {31'd0, rdEmpty}, 32'd1);
    rdByteReq = 1'b1; @(negedge clk); rdByteReq = 1'b0;
    chk("R10 stays empty", {31'd0, rdEmpty}, 32'd1);
  endtask

  task automatic testPriority();
    int n0;
    readyEn = 1'b0;
    setAddr(32'h5000_0000);
    n0 = logN;
    for (int i = 0; i < 8; i++) pushByte(8'(8'h30 + i));
    loadReq = 1'b1; @(negedge clk); loadReq = 1'b0;
    readyEn = 1'b1;
    waitCyc(30);
    chk("R11 six transfers", logN - n0, 6);
    expectLog(n0,   32'h5000_0000, 32'h3031_3233, 1'b1, "R11 write first");
    expectLog(n0+1, 32'h5000_0004, 32'h3435_3637, 1'b1, "R11 write second");
    expectLog(n0+2, 32'h5000_0000, 32'h0000_FFFF, 1'b0, "R11 read after");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    testReset();
    testWrite();
    testPartialCancel();
    testWait();
    testError();
    testFull();
    testRead();
    testPriority();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule